// File: doc/BRIEF.md
# Quadtree Network Router Node

This block is one node of a tree-shaped on-chip network in which every node has four children, one per quadrant, and a parent link. Six ports feed the node. Ports 0 to 3 come from the children and ports 4 and 5 come from the parent. Every port pushes 64-bit packets into its own receive queue. For the packet at the head of each queue, the node works out where it goes from two things: the node's level and position in the tree, and the packet's destination and copy fields. The packet is then written into one or more of six send queues. Logic outside the block drains each send queue through its empty flag and a read strobe.

At level L the node uses one bit of the destination per axis, bit L-1, to choose a child quadrant. A packet from a child climbs to the parent when any of these holds: it belongs to another chip, it names a different subtree above this level, or it asks for copies above this level. A packet from the parent always descends. Copy bits at bit L-1 duplicate a packet into sibling quadrants. When several inputs want the same send queue, they take turns in round-robin order. A multicast packet leaves its receive queue only once every send queue it targets has taken its copy.

The node's tree position (chip X/Y, core X/Y, level) and the queue depths are parameters.

Top module: `qtreeRouter`

## Requirements
- R1: While reset (active low, asynchronous) is held, every send port reports empty.
- R2: The packet layout is as follows. Bits 63:60 are the header, 59:55 chip X, 54:50 chip Y, 49:45 core X, 44:40 core Y, 39:35 copy X and 34:30 copy Y. A packet from a child port (0 to 3) that stays in the subtree is sent to one child only. The child is chosen from core X bit L-1 and core Y bit L-1 as the pair {x,y}: 11 goes to send port 0, 10 to port 1, 01 to port 2 and 00 to port 3.
- R3: A packet from a child port goes to the parent when any of these holds: its chip X or Y differs from the node's own; its core X or Y bits at positions L and above differ from the node's own; or any copy bit at position L or above is set. Packets from ports 0 and 1 leave on send port 4, and packets from ports 2 and 3 leave on send port 5.
- R4: A packet from a parent port (4 or 5) is never sent to the parent. It descends using bit L-1 alone, whatever its chip, high core bits and high copy bits hold.
- R5: Copy Y at bit L-1 sends the packet to both Y children of the selected X. Copy X at bit L-1 sends it to both X children of the selected Y. With both copy bits set, the packet goes to all four children.
- R6: A packet whose header is not 0001 is discarded and appears on no send port.
- R7: Each send port serves competing inputs in round-robin order. After input i is served, the next search starts at input i+1, modulo 6, and the starting point after reset is input 0.
- R8: A multicast packet is delivered exactly once to each send port it targets. It is removed from its receive queue only when all of those ports have taken it.
- R9: Each send port shows its head packet whenever its empty flag is low. A read strobe removes one packet. Packets from one input to one send port keep their order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxWrEn | input | 6 | Per-port write strobe into the receive queue |
| rxData | input | 6x64 | Per-port packet to write |
| txRd | input | 6 | Per-port read strobe on the send queue |
| txData | output | 6x64 | Head packet of each send queue |
| txEmpty | output | 6 | Send queue empty flags |

## Verification
Two functions can fall in the same cycle: the routing of two separate inputs, and the round-robin choice on one send port. The bench writes a pair of packets from child port 0 and parent port 5 in one cycle and a second pair in the next cycle, all bound for send port 3, with the arbiter pointer at input 0. The scoreboard expects the order A1, B1, A2, B2. A fixed-priority arbiter would deliver A1, A2, B1, B2 instead. Multicast packets are judged by requiring exactly one copy on each targeted port and nothing left over once traffic has drained.

// File: rtl/qtreeRouterPkg.sv
package qtreeRouterPkg;
  localparam int NUM_PORTS = 6;
  localparam int NUM_DOWN  = 4;
  localparam int DIR_W     = 5;
  localparam int ADDR_W    = 5;
  localparam int PKT_W     = 64;
  localparam logic [3:0] HDR_VALID = 4'b0001;

  typedef logic [NUM_PORTS-1:0] portVec_t;

  // grant[out][in]: one-hot selection of the input feeding each send queue
  typedef struct packed {
    portVec_t                            rxPop;
    portVec_t                            txPush;
    logic [NUM_PORTS-1:0][NUM_PORTS-1:0] grant;
  } ctrlStrb_t;

  // Direction bits: 0..3 children (positions 11,10,01,00), 4 parent
  function automatic logic [DIR_W-1:0] routeDirs(
    input logic [PKT_W-1:0]  pkt,
    input logic              fromUp,
    input int                level,
    input logic [ADDR_W-1:0] chipX,
    input logic [ADDR_W-1:0] chipY,
    input logic [ADDR_W-1:0] coreX,
    input logic [ADDR_W-1:0] coreY
  );
    logic [ADDR_W-1:0] dChipX, dChipY, dCoreX, dCoreY, cpX, cpY;
    logic leave, dx, dy, cx, cy;
    logic [1:0] pos;
    logic [DIR_W-1:0] r;
    dChipX = pkt[59:55];
    dChipY = pkt[54:50];
    dCoreX = pkt[49:45];
    dCoreY = pkt[44:40];
    cpX    = pkt[39:35];
    cpY    = pkt[34:30];
    leave  = (dChipX != chipX) || (dChipY != chipY);
    for (int b = 0; b < ADDR_W; b++) begin
      if (b >= level)
        leave = leave | (dCoreX[b] != coreX[b]) | (dCoreY[b] != coreY[b]) | cpX[b] | cpY[b];
    end
    dx = dCoreX[level-1];
    dy = dCoreY[level-1];
    cx = cpX[level-1];
    cy = cpY[level-1];
    r = '0;
    if (pkt[63:60] != HDR_VALID) begin
      r = '0;
    end else if (!fromUp && leave) begin
      r[DIR_W-1] = 1'b1;
    end else begin
      for (int j = 0; j < NUM_DOWN; j++) begin
        pos  = 2'(3 - j);
        r[j] = (cx | (pos[1] == dx)) & (cy | (pos[0] == dy));
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/qtFifo.sv
module qtFifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;
  logic          doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == (AW+1)'(DEPTH));
  assign doPush = push & ~full;
  assign doPop  = pop & ~empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      count <= count + (AW+1)'(doPush) - (AW+1)'(doPop);
    end
  end
endmodule

// File: rtl/qtDatapath.sv
module qtDatapath import qtreeRouterPkg::*; #(
  parameter int          LEVEL    = 2,
  parameter logic [4:0]  CHIP_X   = 5'd0,
  parameter logic [4:0]  CHIP_Y   = 5'd0,
  parameter logic [4:0]  CORE_X   = 5'b01000,
  parameter logic [4:0]  CORE_Y   = 5'b00100,
  parameter int          RX_DEPTH = 4,
  parameter int          TX_DEPTH = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_PORTS-1:0]                rxWrEn,
  input  logic [NUM_PORTS-1:0][PKT_W-1:0]     rxData,
  input  ctrlStrb_t                           strb,
  output logic [NUM_PORTS-1:0]                headValid,
  output logic [NUM_PORTS-1:0][DIR_W-1:0]     headDirs,
  output logic [NUM_PORTS-1:0]                txFull,
  input  logic [NUM_PORTS-1:0]                txRd,
  output logic [NUM_PORTS-1:0][PKT_W-1:0]     txData,
  output logic [NUM_PORTS-1:0]                txEmpty
);
  logic [NUM_PORTS-1:0][PKT_W-1:0] rxHead;
  logic [NUM_PORTS-1:0][PKT_W-1:0] txIn;
  logic [NUM_PORTS-1:0]            rxEmpty, rxFull;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : gRx
    qtFifo #(.W(PKT_W), .DEPTH(RX_DEPTH)) rxQ_i (
      .clk(clk), .rstN(rstN),
      .push(rxWrEn[i] & ~rxFull[i]), .pop(strb.rxPop[i]),
      .din(rxData[i]), .dout(rxHead[i]),
      .empty(rxEmpty[i]), .full(rxFull[i])
    );
    assign headValid[i] = ~rxEmpty[i];
    assign headDirs[i]  = routeDirs(rxHead[i], (i >= NUM_DOWN), LEVEL,
                                    CHIP_X, CHIP_Y, CORE_X, CORE_Y);
  end

  for (genvar j = 0; j < NUM_PORTS; j++) begin : gTx
    always_comb begin
      txIn[j] = '0;
      for (int i = 0; i < NUM_PORTS; i++)
        if (strb.grant[j][i]) txIn[j] = rxHead[i];
    end
    qtFifo #(.W(PKT_W), .DEPTH(TX_DEPTH)) txQ_i (
      .clk(clk), .rstN(rstN),
      .push(strb.txPush[j]), .pop(txRd[j]),
      .din(txIn[j]), .dout(txData[j]),
      .empty(txEmpty[j]), .full(txFull[j])
    );
  end
endmodule

// File: rtl/qtControl.sv
module qtControl import qtreeRouterPkg::*; (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_PORTS-1:0]            headValid,
  input  logic [NUM_PORTS-1:0][DIR_W-1:0] headDirs,
  input  logic [NUM_PORTS-1:0]            txFull,
  output ctrlStrb_t                       strb
);
  localparam int PW = $clog2(NUM_PORTS);

  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] need;    // need[in][out]
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] done;    // copies already taken
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] served;  // served[in][out] this cycle
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] req;     // req[out][in]

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      for (int j = 0; j < NUM_DOWN; j++) need[i][j] = headDirs[i][j];
      need[i][4] = headDirs[i][DIR_W-1] & (i < 2);
      need[i][5] = headDirs[i][DIR_W-1] & (i >= 2) & (i < NUM_DOWN);
      for (int j = 0; j < NUM_PORTS; j++) begin
        req[j][i]    = headValid[i] & need[i][j] & ~done[i][j] & ~txFull[j];
        served[i][j] = strb.grant[j][i];
      end
    end
  end

  for (genvar j = 0; j < NUM_PORTS; j++) begin : gArb
    logic [PW-1:0] ptr;
    logic [PW-1:0] win;
    logic          found;
    always_comb begin
      strb.grant[j] = '0;
      win   = '0;
      found = 1'b0;
      for (int k = 0; k < NUM_PORTS; k++) begin
        int idx;
        idx = (int'(ptr) + k) % NUM_PORTS;
        if (!found && req[j][idx]) begin
          strb.grant[j][idx] = 1'b1;
          win   = PW'(idx);
          found = 1'b1;
        end
      end
    end
    assign strb.txPush[j] = found;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ptr <= '0;
      else if (found) ptr <= (win == PW'(NUM_PORTS-1)) ? '0 : win + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : gPop
    assign strb.rxPop[i] = headValid[i] & ((need[i] & ~(done[i] | served[i])) == '0);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              done[i] <= '0;
      else if (strb.rxPop[i]) done[i] <= '0;
      else                    done[i] <= done[i] | served[i];
    end
  end
endmodule

// File: rtl/qtreeRouter.sv
module qtreeRouter import qtreeRouterPkg::*; #(
  parameter int          LEVEL    = 2,
  parameter logic [4:0]  CHIP_X   = 5'd0,
  parameter logic [4:0]  CHIP_Y   = 5'd0,
  parameter logic [4:0]  CORE_X   = 5'b01000,
  parameter logic [4:0]  CORE_Y   = 5'b00100,
  parameter int          RX_DEPTH = 4,
  parameter int          TX_DEPTH = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_PORTS-1:0]            rxWrEn,
  input  logic [NUM_PORTS-1:0][PKT_W-1:0] rxData,
  input  logic [NUM_PORTS-1:0]            txRd,
  output logic [NUM_PORTS-1:0][PKT_W-1:0] txData,
  output logic [NUM_PORTS-1:0]            txEmpty
);
  ctrlStrb_t                       ctrlStrb;
  logic [NUM_PORTS-1:0]            headValid;
  logic [NUM_PORTS-1:0][DIR_W-1:0] headDirs;
  logic [NUM_PORTS-1:0]            txFull;

  qtDatapath #(
    .LEVEL(LEVEL), .CHIP_X(CHIP_X), .CHIP_Y(CHIP_Y),
    .CORE_X(CORE_X), .CORE_Y(CORE_Y),
    .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .rxWrEn(rxWrEn), .rxData(rxData),
    .strb(ctrlStrb), .headValid(headValid), .headDirs(headDirs),
    .txFull(txFull), .txRd(txRd), .txData(txData), .txEmpty(txEmpty)
  );

  qtControl ctl_i (
    .clk(clk), .rstN(rstN), .headValid(headValid), .headDirs(headDirs),
    .txFull(txFull), .strb(ctrlStrb)
  );
endmodule

// File: rtl/qtreeRouterChk.sv
module qtreeRouterChk import qtreeRouterPkg::*; (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] txEmpty,
  input ctrlStrb_t            strb
);
  for (genvar j = 0; j < NUM_PORTS; j++) begin : gChk
    // R7: at most one input feeds a send queue per cycle
    assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(strb.grant[j]));
    // R9: a written send queue shows data in the next cycle
    assert_push_visible_R9: assert property (@(posedge clk) disable iff (!rstN)
      strb.txPush[j] |=> !txEmpty[j]);
  end

  // R3: parent queue 4 fed only by child ports 0,1; queue 5 only by 2,3
  assert_up_split_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.grant[4][5:2] == '0) && (strb.grant[5][1:0] == '0) && (strb.grant[5][5:4] == '0));

  // R4: parent ports never reach a parent send queue
  assert_no_bounce_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.grant[4][5:4] | strb.grant[5][5:4]) == '0);
endmodule

bind qtreeRouter qtreeRouterChk chk_i (
  .clk(clk), .rstN(rstN), .txEmpty(txEmpty), .strb(ctrlStrb)
);

// File: tb/qtreeRouter_tb_top.sv
module qtreeRouter_tb_top;
  import qtreeRouterPkg::*;

  logic clk = 1'b0;
  logic rstN;
  logic [NUM_PORTS-1:0]            rxWrEn;
  logic [NUM_PORTS-1:0][PKT_W-1:0] rxData;
  logic [NUM_PORTS-1:0]            txRd;
  logic [NUM_PORTS-1:0][PKT_W-1:0] txData;
  logic [NUM_PORTS-1:0]            txEmpty;

  int checks = 0;
  int failures = 0;
  logic [63:0] expQ [NUM_PORTS][$];
  int          tagQ [NUM_PORTS][$];

  always #4 clk = ~clk;  // 125 MHz

  // node: level 2, chip 0/0, core X bits[4:2]=010, core Y bits[4:2]=001
  qtreeRouter dut_i (
    .clk(clk), .rstN(rstN), .rxWrEn(rxWrEn), .rxData(rxData),
    .txRd(txRd), .txData(txData), .txEmpty(txEmpty)
  );

  function automatic logic [63:0] mk(input logic [3:0] hdr, input logic [4:0] chX, chY,
                                     cX, cY, cpX, cpY, input logic [29:0] pay);
    return {hdr, chX, chY, cX, cY, cpX, cpY, pay};
  endfunction

  function automatic logic [4:0] dX(input logic x); return 5'b01000 | {3'b0, x, 1'b0}; endfunction
  function automatic logic [4:0] dY(input logic y); return 5'b00100 | {3'b0, y, 1'b0}; endfunction

  task automatic chk(input bit ok, input int tag, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: stage a write and record expected copies
  task automatic put(input int port, input logic [63:0] pkt, input logic [5:0] outMask, input int tag);
    rxWrEn[port] = 1'b1;
    rxData[port] = pkt;
    for (int j = 0; j < NUM_PORTS; j++)
      if (outMask[j]) begin expQ[j].push_back(pkt); tagQ[j].push_back(tag); end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    rxWrEn = '0;
    rxData = '0;
  endtask

  task automatic settle();
    repeat (10) tick();
  endtask

  // monitor: R9 show-ahead data is compared and popped with a read strobe
  always @(negedge clk) begin
    for (int j = 0; j < NUM_PORTS; j++) begin
      txRd[j] = 1'b0;
      if (rstN === 1'b1 && txEmpty[j] === 1'b0) begin
        if (expQ[j].size() == 0) begin
          chk(1'b0, 8, txData[j], 64'h0);  // R6 / R8: unexpected packet
        end else begin
          logic [63:0] e;
          int t;
          e = expQ[j].pop_front();
          t = tagQ[j].pop_front();
          chk(txData[j] === e, t, txData[j], e);
        end
        txRd[j] = 1'b1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    rxWrEn = '0;
    rxData = '0;
    txRd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(txEmpty == 6'h3f, 1, 64'(txEmpty), 64'h3f);  // R1
    @(posedge clk); #1;
    rstN = 1'b1;
    tick();

    // R2: unicast to each child from child ports
    put(0, mk(4'b0001, 0, 0, dX(0), dY(0), 0, 0, 30'd1), 6'b001000, 2);
    put(1, mk(4'b0001, 0, 0, dX(1), dY(1), 0, 0, 30'd2), 6'b000001, 2);
    put(2, mk(4'b0001, 0, 0, dX(1), dY(0), 0, 0, 30'd3), 6'b000010, 2);
    put(3, mk(4'b0001, 0, 0, dX(0), dY(1), 0, 0, 30'd4), 6'b000100, 2);
    tick(); settle();

    // R3: other chip climbs; port 1 -> send 4, port 2 -> send 5
    put(1, mk(4'b0001, 5'd3, 0, dX(0), dY(0), 0, 0, 30'd5), 6'b010000, 3);
    put(2, mk(4'b0001, 0, 5'd1, dX(0), dY(0), 0, 0, 30'd6), 6'b100000, 3);
    tick(); settle();

    // R3: cousin subtree, and copy bit above the level
    put(3, mk(4'b0001, 0, 0, 5'b11010, dY(0), 0, 0, 30'd7), 6'b100000, 3);
    put(0, mk(4'b0001, 0, 0, dX(0), dY(0), 5'b00100, 0, 30'd8), 6'b010000, 3);
    tick(); settle();

    // R4: parent ports descend regardless of chip / high bits / high copies
    put(4, mk(4'b0001, 5'd9, 0, 5'b10010, 5'b00000, 0, 0, 30'd9), 6'b000010, 4);
    put(5, mk(4'b0001, 0, 0, dX(0), dY(0), 0, 5'b10000, 30'd10), 6'b001000, 4);
    tick(); settle();

    // R5: copy Y with x=1 -> positions 11 and 10
    put(0, mk(4'b0001, 0, 0, dX(1), dY(0), 0, 5'b00010, 30'd11), 6'b000011, 5);
    tick(); settle();
    // R5: copy X with y=0 -> positions 10 and 00
    put(1, mk(4'b0001, 0, 0, dX(0), dY(0), 5'b00010, 0, 30'd12), 6'b001010, 5);
    tick(); settle();
    // R5 / R8: both copies from a parent port -> all four children once each
    put(5, mk(4'b0001, 0, 0, dX(0), dY(1), 5'b00010, 5'b00010, 30'd13), 6'b001111, 8);
    tick(); settle();

    // R6: bad headers are discarded (monitor flags any output)
    put(2, mk(4'b0000, 0, 0, dX(1), dY(1), 0, 0, 30'd14), 6'b000000, 6);
    put(3, mk(4'b1111, 5'd3, 0, dX(0), dY(0), 0, 0, 30'd15), 6'b000000, 6);
    tick(); settle();

    // R7 / R9: two inputs contend for send 3, pointer at input 0
    put(0, mk(4'b0001, 0, 0, dX(0), dY(0), 0, 0, 30'd16), 6'b001000, 7);  // A1
    put(5, mk(4'b0001, 0, 0, dX(0), dY(0), 0, 0, 30'd17), 6'b001000, 7);  // B1
    tick();
    put(0, mk(4'b0001, 0, 0, dX(0), dY(0), 0, 0, 30'd18), 6'b001000, 7);  // A2
    put(5, mk(4'b0001, 0, 0, dX(0), dY(0), 0, 0, 30'd19), 6'b001000, 7);  // B2
    tick();
    repeat (3) settle();

    // R8: nothing missing on any port
    for (int j = 0; j < NUM_PORTS; j++)
      chk(expQ[j].size() == 0, 8, 64'(expQ[j].size()), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule